// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every instruction fetch and every data access, whether the access may proceed and how the target memory is to be treated. Instruction and data traffic each have an independent set of eight protection regions. A region is described by a base address, a power-of-two size from 4 KB up to the whole 4 GB space, an enable flag, a cacheable flag, a bufferable flag, and two permission fields: one applies to user-level accesses and one to supervisor-level accesses.

Regions are programmed through a single-word write port that selects the side and the region index. Each lookup is purely combinational from the stored region state. In the same cycle as the address, the block reports whether the access is allowed, raises an abort when it is not, and returns the cacheable and bufferable attributes of the winning region. When regions overlap, the highest-numbered matching region wins. An access that falls in no enabled region aborts and is treated as non-cacheable and non-bufferable. A global enable input turns all checking off.

Top module: `prot_region_unit`

## Requirements
- R1: After reset every region on both sides is disabled, so with checking enabled every valid access aborts and reports cacheable=0 and bufferable=0.
- R2: A write with `cfgWe=1` loads `cfgData` into the region chosen by `cfgIdx` on the side chosen by `cfgSide` (0 = instruction, 1 = data), taking effect from the next clock edge. Field layout: [31:12] base address bits 31..12, [11:7] size code, [6] enable, [5] cacheable, [4] bufferable, [3:2] supervisor permission, [1:0] user permission. Writing enable=0 removes the region from lookups.
- R3: Size code n covers 2^(n+12) bytes for n below 20; codes 20 and above cover the full address space. Base address bits below the region size are ignored, so a region always starts on a boundary of its own size.
- R4: When several enabled regions match an address, the attributes and permissions of the highest-numbered one are used.
- R5: Permissions: the supervisor field is used when the privilege input is 1, the user field when it is 0. Within a field, bit 0 allows reads and instruction fetches and bit 1 allows data writes. An access without the needed bit aborts.
- R6: An access that matches no enabled region aborts and reports cacheable=0 and bufferable=0.
- R7: When a region matches, its cacheable and bufferable bits are reported even if the access is denied by permission.
- R8: Abort is combinational: it is raised in the same cycle as the access inputs, and only when the side's valid input is 1.
- R9: With `protEn=0` every access is allowed, abort stays 0, and cacheable and bufferable are 0.
- R10: The two sides are independent: writing one side's regions never changes the results on the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| protEn | input | 1 | Global checking enable |
| cfgWe | input | 1 | Region write strobe |
| cfgSide | input | 1 | Side select for the write: 0 instruction, 1 data |
| cfgIdx | input | 3 | Region index for the write |
| cfgData | input | 32 | Region descriptor word |
| iValid | input | 1 | Instruction fetch present |
| iPriv | input | 1 | Fetch privilege: 1 supervisor, 0 user |
| iAddr | input | 32 | Fetch address |
| iAllow | output | 1 | Fetch permitted |
| iAbort | output | 1 | Fetch abort |
| iCacheable | output | 1 | Fetch target cacheable |
| iBufferable | output | 1 | Fetch target bufferable |
| dValid | input | 1 | Data access present |
| dPriv | input | 1 | Data privilege: 1 supervisor, 0 user |
| dWrite | input | 1 | Data access is a write |
| dAddr | input | 32 | Data address |
| dAllow | output | 1 | Data access permitted |
| dAbort | output | 1 | Data abort |
| dCacheable | output | 1 | Data target cacheable |
| dBufferable | output | 1 | Data target bufferable |

## Verification
The bench probes both edges of a 64 KB region and an unaligned base, which a design that skipped the base masking or used an off-by-one size would misplace. It stacks regions at the same base so that a design resolving overlap toward the lower index, or keeping a stale match after a region is disabled, returns the wrong attributes. It separates read from write and user from supervisor on the same region, which catches a swapped permission field or bit. It also checks that a denied access still carries its region's attributes, that a miss clears them, that an invalid access never aborts, and that programming one side leaves the other side's answers unchanged.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

  parameter int ADDR_W      = 32;
  parameter int MIN_SHIFT   = 12;
  parameter int NUM_REGIONS = 8;
  parameter int NUM_SIDES   = 2;
  parameter int SIZE_W      = 5;
  parameter int PERM_W      = 2;

  localparam int BASE_W = ADDR_W - MIN_SHIFT;
  localparam int IDX_W  = $clog2(NUM_REGIONS);
  localparam int CFG_W  = BASE_W + SIZE_W + 3 + 2 * PERM_W;

  localparam int SIDE_INSTR = 0;
  localparam int SIDE_DATA  = 1;

  // Field order matches the descriptor word written through the config port.
  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [SIZE_W-1:0] sizeCode;
    logic              enable;
    logic              cacheable;
    logic              bufferable;
    logic [PERM_W-1:0] supPerm;
    logic [PERM_W-1:0] usrPerm;
  } region_t;

  typedef struct packed {
    logic [NUM_SIDES-1:0][NUM_REGIONS-1:0] wr;
  } cfg_strobe_t;

endpackage

// File: rtl/prot_region_ctrl.sv
module prot_region_ctrl
  import prot_region_pkg::*;
(
  input  logic             cfgWe,
  input  logic             cfgSide,
  input  logic [IDX_W-1:0] cfgIdx,
  output cfg_strobe_t      strobes
);

  always_comb begin
    strobes = '0;
    for (int s = 0; s < NUM_SIDES; s++) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (cfgWe && (int'(cfgSide) == s) && (int'(cfgIdx) == r)) begin
          strobes.wr[s][r] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/prot_region_lookup.sv
module prot_region_lookup
  import prot_region_pkg::*;
(
  input  region_t           regs [NUM_REGIONS],
  input  logic [ADDR_W-1:0] addr,
  input  logic              priv,
  input  logic              isWrite,
  input  logic              valid,
  input  logic              protEn,
  output logic              allow,
  output logic              abort,
  output logic              cacheable,
  output logic              bufferable
);

  logic              hit;
  region_t           winner;
  logic [PERM_W-1:0] perm;
  logic              permOk;

  function automatic logic regionMatch(input region_t rg, input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] baseAddr;
    int                sh;
    sh       = int'(rg.sizeCode) + MIN_SHIFT;
    mask     = (sh >= ADDR_W) ? '0 : ({ADDR_W{1'b1}} << sh);
    baseAddr = {rg.base, {MIN_SHIFT{1'b0}}};
    return rg.enable && ((a & mask) == (baseAddr & mask));
  endfunction

  // Ascending scan: a later (higher-numbered) match overrides earlier ones.
  always_comb begin
    hit    = 1'b0;
    winner = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (regionMatch(regs[r], addr)) begin
        hit    = 1'b1;
        winner = regs[r];
      end
    end
  end

  always_comb begin
    perm   = priv ? winner.supPerm : winner.usrPerm;
    permOk = isWrite ? perm[1] : perm[0];
    if (!protEn) begin
      allow      = 1'b1;
      abort      = 1'b0;
      cacheable  = 1'b0;
      bufferable = 1'b0;
    end else begin
      allow      = hit && permOk;
      abort      = valid && !(hit && permOk);
      cacheable  = hit && winner.cacheable;
      bufferable = hit && winner.bufferable;
    end
  end

endmodule

// File: rtl/prot_region_datapath.sv
module prot_region_datapath
  import prot_region_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              protEn,
  input  cfg_strobe_t       strobes,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              iValid,
  input  logic              iPriv,
  input  logic [ADDR_W-1:0] iAddr,
  output logic              iAllow,
  output logic              iAbort,
  output logic              iCacheable,
  output logic              iBufferable,
  input  logic              dValid,
  input  logic              dPriv,
  input  logic              dWrite,
  input  logic [ADDR_W-1:0] dAddr,
  output logic              dAllow,
  output logic              dAbort,
  output logic              dCacheable,
  output logic              dBufferable
);

  region_t regs [NUM_SIDES][NUM_REGIONS];

  logic [NUM_SIDES-1:0]             sValid, sPriv, sWrite;
  logic [NUM_SIDES-1:0][ADDR_W-1:0] sAddr;
  logic [NUM_SIDES-1:0]             sAllow, sAbort, sCache, sBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SIDES; s++) begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
          regs[s][r] <= '0;
        end
      end
    end else begin
      for (int s = 0; s < NUM_SIDES; s++) begin
        for (int r = 0; r < NUM_REGIONS; r++) begin
          if (strobes.wr[s][r]) begin
            regs[s][r] <= region_t'(cfgData);
          end
        end
      end
    end
  end

  assign sValid[SIDE_INSTR] = iValid;
  assign sPriv [SIDE_INSTR] = iPriv;
  assign sWrite[SIDE_INSTR] = 1'b0;
  assign sAddr [SIDE_INSTR] = iAddr;
  assign sValid[SIDE_DATA]  = dValid;
  assign sPriv [SIDE_DATA]  = dPriv;
  assign sWrite[SIDE_DATA]  = dWrite;
  assign sAddr [SIDE_DATA]  = dAddr;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    prot_region_lookup u_lookup (
      .regs      (regs[s]),
      .addr      (sAddr[s]),
      .priv      (sPriv[s]),
      .isWrite   (sWrite[s]),
      .valid     (sValid[s]),
      .protEn    (protEn),
      .allow     (sAllow[s]),
      .abort     (sAbort[s]),
      .cacheable (sCache[s]),
      .bufferable(sBuf[s])
    );
  end

  assign iAllow      = sAllow[SIDE_INSTR];
  assign iAbort      = sAbort[SIDE_INSTR];
  assign iCacheable  = sCache[SIDE_INSTR];
  assign iBufferable = sBuf[SIDE_INSTR];
  assign dAllow      = sAllow[SIDE_DATA];
  assign dAbort      = sAbort[SIDE_DATA];
  assign dCacheable  = sCache[SIDE_DATA];
  assign dBufferable = sBuf[SIDE_DATA];

endmodule

// File: rtl/prot_region_unit.sv
module prot_region_unit
  import prot_region_pkg::*;
#(
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_IDX_W   = IDX_W,
  parameter int P_CFG_W   = CFG_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                protEn,
  input  logic                cfgWe,
  input  logic                cfgSide,
  input  logic [P_IDX_W-1:0]  cfgIdx,
  input  logic [P_CFG_W-1:0]  cfgData,
  input  logic                iValid,
  input  logic                iPriv,
  input  logic [P_ADDR_W-1:0] iAddr,
  output logic                iAllow,
  output logic                iAbort,
  output logic                iCacheable,
  output logic                iBufferable,
  input  logic                dValid,
  input  logic                dPriv,
  input  logic                dWrite,
  input  logic [P_ADDR_W-1:0] dAddr,
  output logic                dAllow,
  output logic                dAbort,
  output logic                dCacheable,
  output logic                dBufferable
);

  cfg_strobe_t strobes;

  prot_region_ctrl u_ctrl (
    .cfgWe  (cfgWe),
    .cfgSide(cfgSide),
    .cfgIdx (cfgIdx),
    .strobes(strobes)
  );

  prot_region_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .protEn     (protEn),
    .strobes    (strobes),
    .cfgData    (cfgData),
    .iValid     (iValid),
    .iPriv      (iPriv),
    .iAddr      (iAddr),
    .iAllow     (iAllow),
    .iAbort     (iAbort),
    .iCacheable (iCacheable),
    .iBufferable(iBufferable),
    .dValid     (dValid),
    .dPriv      (dPriv),
    .dWrite     (dWrite),
    .dAddr      (dAddr),
    .dAllow     (dAllow),
    .dAbort     (dAbort),
    .dCacheable (dCacheable),
    .dBufferable(dBufferable)
  );

endmodule

// File: rtl/prot_region_chk.sv
module prot_region_chk
  import prot_region_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              protEn,
  input logic              cfgWe,
  input logic              cfgSide,
  input logic              iValid,
  input logic              iPriv,
  input logic [ADDR_W-1:0] iAddr,
  input logic              iAllow,
  input logic              iAbort,
  input logic              iCacheable,
  input logic              iBufferable,
  input logic              dValid,
  input logic              dAbort,
  input logic              dCacheable,
  input logic              dBufferable
);

  logic instrWritten;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   instrWritten <= 1'b0;
    else if (cfgWe && !cfgSide)  instrWritten <= 1'b1;
  end

  // R1
  reset_state_aborts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (protEn && iValid && !instrWritten) |-> (iAbort && !iCacheable && !iBufferable));

  // R8
  abort_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iAbort |-> iValid) and (dAbort |-> dValid));

  // R9
  bypass_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    !protEn |-> (iAllow && !iAbort && !iCacheable && !iBufferable && !dAbort && !dCacheable && !dBufferable));

  // R10
  side_isolation_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSide) |=>
      (!($stable(iAddr) && $stable(iPriv) && $stable(iValid) && $stable(protEn)) ||
       ($stable(iAllow) && $stable(iAbort) && $stable(iCacheable) && $stable(iBufferable))));

endmodule

bind prot_region_unit prot_region_chk chk_i (.*);

// File: tb/prot_region_unit_tb_top.sv
module prot_region_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        protEn;
  logic        cfgWe;
  logic        cfgSide;
  logic [2:0]  cfgIdx;
  logic [31:0] cfgData;
  logic        iValid, iPriv;
  logic [31:0] iAddr;
  logic        iAllow, iAbort, iCacheable, iBufferable;
  logic        dValid, dPriv, dWrite;
  logic [31:0] dAddr;
  logic        dAllow, dAbort, dCacheable, dBufferable;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prot_region_unit dut_i (.*);

  function automatic logic [31:0] desc(input logic [31:0] base, input int code,
      input logic en, input logic c, input logic b,
      input logic [1:0] sup, input logic [1:0] usr);
    logic [4:0] sc;
    sc = 5'(code);
    return {base[31:12], sc, en, c, b, sup, usr};
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic writeRegion(input logic side, input int idx, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSide = side; cfgIdx = 3'(idx); cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic dAccess(input logic [31:0] a, input logic p, input logic w,
      input string req, input logic eAllow, input logic eAbort, input logic eC, input logic eB);
    @(negedge clk);
    dValid = 1'b1; dAddr = a; dPriv = p; dWrite = w;
    #1;
    chk(req, $sformatf("d allow @%h", a), dAllow, eAllow);
    chk(req, $sformatf("d abort @%h", a), dAbort, eAbort);
    chk(req, $sformatf("d cacheable @%h", a), dCacheable, eC);
    chk(req, $sformatf("d bufferable @%h", a), dBufferable, eB);
  endtask

  task automatic iAccess(input logic [31:0] a, input logic p, input logic v,
      input string req, input logic eAllow, input logic eAbort, input logic eC, input logic eB);
    @(negedge clk);
    iValid = v; iAddr = a; iPriv = p;
    #1;
    chk(req, $sformatf("i allow @%h", a), iAllow, eAllow);
    chk(req, $sformatf("i abort @%h", a), iAbort, eAbort);
    chk(req, $sformatf("i cacheable @%h", a), iCacheable, eC);
    chk(req, $sformatf("i bufferable @%h", a), iBufferable, eB);
  endtask

  // R1: nothing enabled after reset
  task automatic t_reset();
    iAccess(32'h0000_0000, 1'b1, 1'b1, "R1", 1'b0, 1'b1, 1'b0, 1'b0);
    dAccess(32'hFFFF_F000, 1'b1, 1'b0, "R1", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  // R2 R5 R7 R10: full-space data region, user read-only
  task automatic t_perms();
    writeRegion(1'b1, 0, desc(32'h0, 20, 1, 0, 1, 2'b11, 2'b01));
    dAccess(32'h0000_1234, 1'b0, 1'b0, "R5", 1'b1, 1'b0, 1'b0, 1'b1);
    dAccess(32'h0000_1234, 1'b0, 1'b1, "R7", 1'b0, 1'b1, 1'b0, 1'b1);
    dAccess(32'h0000_1234, 1'b1, 1'b1, "R5", 1'b1, 1'b0, 1'b0, 1'b1);
    iAccess(32'h0000_1234, 1'b1, 1'b1, "R10", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  // R3 R4: 64 KB region edges and an unaligned base
  task automatic t_size();
    writeRegion(1'b1, 1, desc(32'h0004_0000, 4, 1, 1, 0, 2'b11, 2'b11));
    dAccess(32'h0004_0000, 1'b0, 1'b1, "R3", 1'b1, 1'b0, 1'b1, 1'b0);
    dAccess(32'h0004_FFFF, 1'b0, 1'b1, "R3", 1'b1, 1'b0, 1'b1, 1'b0);
    dAccess(32'h0005_0000, 1'b0, 1'b0, "R3", 1'b1, 1'b0, 1'b0, 1'b1);
    dAccess(32'h0003_FFFC, 1'b0, 1'b0, "R3", 1'b1, 1'b0, 1'b0, 1'b1);
    writeRegion(1'b1, 2, desc(32'h0008_3000, 3, 1, 1, 1, 2'b11, 2'b00));
    dAccess(32'h0008_0000, 1'b1, 1'b0, "R3", 1'b1, 1'b0, 1'b1, 1'b1);
    dAccess(32'h0008_0004, 1'b0, 1'b0, "R7", 1'b0, 1'b1, 1'b1, 1'b1);
    dAccess(32'h0008_8000, 1'b0, 1'b0, "R3", 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  // R4 R2: higher index wins; disabling restores lower region
  task automatic t_priority();
    writeRegion(1'b1, 7, desc(32'h0004_0000, 0, 1, 0, 0, 2'b11, 2'b11));
    dAccess(32'h0004_0010, 1'b0, 1'b0, "R4", 1'b1, 1'b0, 1'b0, 1'b0);
    dAccess(32'h0004_1000, 1'b0, 1'b0, "R4", 1'b1, 1'b0, 1'b1, 1'b0);
    writeRegion(1'b1, 7, desc(32'h0004_0000, 0, 0, 0, 0, 2'b11, 2'b11));
    dAccess(32'h0004_0010, 1'b0, 1'b0, "R2", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  // R5 R6 R10: instruction side regions, misses, data side untouched
  task automatic t_instr();
    writeRegion(1'b0, 3, desc(32'h1000_0000, 8, 1, 1, 0, 2'b01, 2'b00));
    iAccess(32'h1000_0100, 1'b1, 1'b1, "R5", 1'b1, 1'b0, 1'b1, 1'b0);
    iAccess(32'h1000_0100, 1'b0, 1'b1, "R5", 1'b0, 1'b1, 1'b1, 1'b0);
    iAccess(32'h2000_0000, 1'b1, 1'b1, "R6", 1'b0, 1'b1, 1'b0, 1'b0);
    iAccess(32'h100F_FFFF, 1'b1, 1'b1, "R3", 1'b1, 1'b0, 1'b1, 1'b0);
    dAccess(32'h1000_0100, 1'b0, 1'b0, "R10", 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  // R6: data miss once the full-space region is disabled
  task automatic t_miss();
    writeRegion(1'b1, 0, desc(32'h0, 20, 0, 0, 1, 2'b11, 2'b11));
    dAccess(32'h7000_0000, 1'b1, 1'b0, "R6", 1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  // R8: no abort without valid
  task automatic t_valid();
    iAccess(32'h2000_0000, 1'b1, 1'b0, "R8", 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // R9: bypass
  task automatic t_bypass();
    @(negedge clk);
    protEn = 1'b0;
    iAccess(32'h2000_0000, 1'b0, 1'b1, "R9", 1'b1, 1'b0, 1'b0, 1'b0);
    dAccess(32'h0004_0000, 1'b0, 1'b1, "R9", 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    protEn = 1'b1;
  endtask

  initial begin
    fork
      begin
        rstN = 1'b0; protEn = 1'b1; cfgWe = 1'b0; cfgSide = 1'b0; cfgIdx = '0; cfgData = '0;
        iValid = 1'b0; iPriv = 1'b0; iAddr = '0;
        dValid = 1'b0; dPriv = 1'b0; dWrite = 1'b0; dAddr = '0;
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_perms();
        t_size();
        t_priority();
        t_instr();
        t_miss();
        t_valid();
        t_bypass();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule